// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus when a slave device has been left mid-byte and keeps SDA pulled low. On a single-cycle start request it plays a fixed, timed waveform on SCL and SDA. The waveform opens with an idle hold, continues with a burst of clock pulses so the slave can shift out whatever bit it was holding, and ends with a STOP condition and a final idle wait. The slave's responses are not sampled, and the block does not judge whether the recovery worked.

Both lines are presented as pull-low enables. The top level maps each enable onto an open-drain pad, so a deasserted enable leaves the line to its pull-up and it reads as 1. All timing is counted in quarter bit periods. An internal divider derives the quarter period from the system clock rate and the bus bit rate.

Top module: `i2c_bus_unjam`

## Requirements
- R1: After reset, and whenever the sequencer is idle, `scl_pull_o` and `sda_pull_o` are 0 and `busy_o` and `done_o` are 0. A reset asserted mid-sequence returns the block to this idle state.
- R2: A 1 on `start_i` while idle is taken at that clock edge, and `busy_o` reads 1 from the next cycle. Quarters 0 to 7 of the sequence keep both pull enables at 0.
- R3: Quarters 8 to 43 form 9 SCL pulses. In each group of four quarters, `scl_pull_o` is 1 for the first two and 0 for the last two. `sda_pull_o` stays 0 through all of them.
- R4: Quarter 44 releases both lines (both enables 0).
- R5: Quarters 45 to 47 form the STOP condition, with each step one quarter long. Quarter 45 has both enables at 1. Quarter 46 has SCL released and SDA pulled. Quarter 47 has both lines released.
- R6: Quarters 48 to 55 keep both lines released. At the end of quarter 55, `done_o` is 1 for exactly one cycle, and `busy_o` drops in that same cycle.
- R7: One quarter lasts `CLK_HZ/BIT_HZ/4` clock cycles, with a minimum of 1. The default `BIT_HZ` is 50000. With the bench setting of 4 cycles per quarter, the first SCL pull begins 32 cycles after the start edge.
- R8: A start request that arrives while `busy_o` is 1 is ignored. The running sequence keeps its timing and values.
- R9: The pull enables change only at quarter boundaries and hold steady within a quarter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run the recovery sequence |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the sequence ends |
| scl_pull_o | output | 1 | 1 pulls SCL low; 0 releases it |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The block holds only a quarter index, a divider and a busy flag. A wrong index therefore appears at the pins within one quarter, as a pull enable that does not match the position in the waveform. A slip in the divider shifts the first SCL pull away from its expected cycle, and the error then grows at every later edge. The bench compares both enables on every clock cycle against a waveform built from quarter numbers. It also checks where the done pulse falls. A spurious restart or a miscounted pulse train therefore fails at the first wrong cycle.

// File: rtl/i2c_bus_unjam.sv
module i2c_bus_unjam #(
  parameter int CLK_HZ    = 100_000_000,
  parameter int BIT_HZ    = 50_000,
  parameter int HOLD_Q    = 8,
  parameter int PULSE_CNT = 9,
  parameter int TAIL_Q    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic scl_pull_o,
  output logic sda_pull_o
);
  localparam int RAW_Q     = CLK_HZ / BIT_HZ / 4;
  localparam int QUARTER   = (RAW_Q < 1) ? 1 : RAW_Q;
  localparam int DIV_W     = (QUARTER < 2) ? 1 : $clog2(QUARTER);
  localparam int PULSE_END = HOLD_Q + 4 * PULSE_CNT;
  localparam int STOP_A    = PULSE_END + 1;
  localparam int LAST_Q    = STOP_A + 3 + TAIL_Q - 1;
  localparam int IDX_W     = $clog2(LAST_Q + 1);

  logic             busy_q, done_q, scl_q, sda_q, tick;
  logic [DIV_W-1:0] div_q;
  logic [IDX_W-1:0] idx_q;

  // {scl pull, sda pull} for quarter k of the sequence
  function automatic logic [1:0] pattern(input int k);
    if (k >= HOLD_Q && k < PULSE_END)
      return {(((k - HOLD_Q) & 3) < 2), 1'b0};
    else if (k == STOP_A)
      return 2'b11;
    else if (k == STOP_A + 1)
      return 2'b01;
    else
      return 2'b00;
  endfunction

  assign tick = busy_q && (div_q == DIV_W'(QUARTER - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      div_q  <= '0;
      idx_q  <= '0;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        div_q <= '0;
        if (start_i) begin
          busy_q         <= 1'b1;
          idx_q          <= '0;
          {scl_q, sda_q} <= pattern(0);
        end
      end else if (tick) begin
        div_q <= '0;
        if (int'(idx_q) == LAST_Q) begin
          busy_q         <= 1'b0;
          done_q         <= 1'b1;
          idx_q          <= '0;
          {scl_q, sda_q} <= 2'b00;
        end else begin
          idx_q          <= idx_q + 1'b1;
          {scl_q, sda_q} <= pattern(int'(idx_q) + 1);
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign scl_pull_o = scl_q;
  assign sda_pull_o = sda_q;

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!scl_q && !sda_q));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R6
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  // R9
  quarter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> $stable({scl_q, sda_q}));
  // R3
  sda_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && int'(idx_q) < PULSE_END) |-> !sda_q);
  // R5
  stop_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_q) |-> !scl_q);
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && !tick) |=> busy_q);
endmodule

// File: tb/i2c_bus_unjam_tb.sv
module i2c_bus_unjam_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 4;
  localparam int NQ         = 56;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic busy_o, done_o, scl_pull_o, sda_pull_o;
  int   total = 0, bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_bus_unjam #(.CLK_HZ(800_000), .BIT_HZ(50_000)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_pull(input int k);
    if (k >= 8 && k < 44) return (((k - 8) % 4) < 2) ? 2 : 0;
    if (k == 45) return 3;
    if (k == 46) return 1;
    return 0;
  endfunction

  function automatic string tag(input int k);
    if (k < 8)   return "R2";
    if (k < 44)  return "R3";
    if (k == 44) return "R4";
    if (k < 48)  return "R5";
    return "R6";
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset busy", busy_o, 0);
    chk("R1 reset done", done_o, 0);
    chk("R1 reset pulls", {scl_pull_o, sda_pull_o}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 idle busy", busy_o, 0);
    chk("R1 idle pulls", {scl_pull_o, sda_pull_o}, 0);
  endtask

  task automatic t_sequence(input int spur_cycle);
    int first_scl = -1;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 0; c < NQ * Q; c++) begin
      if (c > 0) @(negedge clk);
      start_i = (c == spur_cycle);
      chk((c == spur_cycle) ? "R8 busy" : "R2 busy", busy_o, 1);
      chk(tag(c / Q), {scl_pull_o, sda_pull_o}, exp_pull(c / Q));
      if (c % Q != 0) chk("R9 steady", {scl_pull_o, sda_pull_o}, exp_pull(c / Q));
      chk("R6 no early done", done_o, 0);
      if (first_scl < 0 && scl_pull_o) first_scl = c;
    end
    @(negedge clk);
    start_i = 1'b0;
    chk("R6 done pulse", done_o, 1);
    chk("R6 busy low", busy_o, 0);
    chk("R7 first scl pull cycle", first_scl, 8 * Q);
    @(negedge clk);
    chk("R6 done one cycle", done_o, 0);
    chk("R6 released", {scl_pull_o, sda_pull_o}, 0);
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (45 * Q + 1) @(negedge clk);
    chk("R5 stop step before reset", {scl_pull_o, sda_pull_o}, 3);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset busy", busy_o, 0);
    chk("R1 mid reset pulls", {scl_pull_o, sda_pull_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_sequence(-1);
    t_sequence(100);
    t_sequence(NQ * Q - 1);
    t_mid_reset();
    t_sequence(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule